// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block sits in the feedback path of a frequency synthesizer loop. It divides a fast input clock by N = B·P + A and emits one short pulse per output cycle for the phase detector. The divide is built from three parts. A dual-modulus prescaler divides by P or P+1, and it is built on a synchronous divide-by-4/5 core. A swallow counter holds A and a main counter holds B. For the first A prescaler cycles of every output cycle the prescaler divides by P+1. For the rest of the B prescaler cycles it divides by P. One select bit picks P = 32 or P = 64.

New values for the swallow count, the main count and the modulus are written through a load strobe. They are held aside and take effect only at the next output-cycle boundary, so a cycle already in progress is never cut short or stretched. Loading a main count smaller than the swallow count is a setup error. The block then raises a sticky flag and runs that setting with no swallow, which gives a plain B·P divide.

Top module: `pulse_swallow_div`

## Requirements
- R1: With the modulus select low (P = 32), the number of input clocks from one output pulse to the next is B·32 + A.
- R2: With the modulus select high (P = 64), the number of input clocks between output pulses is B·64 + A.
- R3: A swallow count of 0 gives an interval of exactly B·P clocks.
- R4: A swallow count equal to the main count is legal and gives B·P + B clocks, with no error flag.
- R5: The extreme main counts work. B = 1 gives P + A, and B = 2047 with A = 63 and P = 32 gives 65567 clocks.
- R6: The output pulse is high for exactly one input clock per output cycle.
- R7: A load strobe does not change the length of the output cycle in which it arrives. The new setting governs the cycle that starts at the following pulse.
- R8: Loading a main count below the swallow count sets the error flag once the setting is applied. That setting then divides by B·P.
- R9: The error flag stays set through later valid loads and is cleared only by reset.
- R10: After reset the output and the error flag are low. The divider runs with B = 1, A = 0 and P = 32, a 32-clock interval, until a load is applied.
- R11: When several loads arrive within one output cycle, only the last one takes effect at the boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous reset, active high |
| cfg_load | input | 1 | One-clock strobe that captures the three setting inputs |
| swallow_val | input | 6 | Swallow count A (0 to 63) |
| main_val | input | 11 | Main count B (1 to 2047) |
| mod_hi_sel | input | 1 | 0 selects P = 32, 1 selects P = 64 |
| fb_pulse | output | 1 | One-clock feedback pulse at each output-cycle boundary |
| ratio_err | output | 1 | Sticky flag: a main count below the swallow count was applied |

## Verification
The bench builds the block with its default widths: a 6-bit swallow count, an 11-bit main count and prescaler moduli of 32/33 and 64/65. With these widths the full legal range of both counts can be reached. That includes the longest interval (B = 2047, A = 63) and the shortest (B = 1, A = 0). The bench measures the clocks between pulses and compares each count with B·P + A. It checks both moduli, the A = 0 and A = B edges, a load that arrives mid-cycle, several loads inside one cycle, and the fallback that follows a setting with B < A.

// File: rtl/psw_pkg.sv
package psw_pkg;
    parameter int A_W   = 6;
    parameter int B_W   = 11;
    parameter int P_LO  = 32;
    parameter int P_HI  = 64;

    typedef struct packed {
        logic [A_W-1:0] a;
        logic [B_W-1:0] b;
        logic           p_hi;
    } div_cfg_t;
endpackage

// File: rtl/psw_prescaler.sv
module psw_prescaler
    import psw_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic mc_next,
    input  logic p_hi_next,
    output logic tick
);
    localparam int SEG_LO = P_LO / 4;
    localparam int SEG_HI = P_HI / 4;
    localparam int EXT_W  = $clog2(SEG_HI);
    localparam logic [EXT_W-1:0] EXT_LO = EXT_W'(SEG_LO - 1);
    localparam logic [EXT_W-1:0] EXT_HI = EXT_W'(SEG_HI - 1);

    typedef struct packed {
        logic [2:0]       core;
        logic [EXT_W-1:0] ext;
    } pre_t;

    pre_t st_d, st_q;

    assign tick = (st_q.core == 3'd0) && (st_q.ext == '0);

    always_comb begin
        st_d = st_q;
        if (st_q.core != 3'd0) begin
            st_d.core = st_q.core - 3'd1;
        end else if (st_q.ext != '0) begin
            st_d.ext  = st_q.ext - 1'b1;
            st_d.core = 3'd3;
        end else begin
            st_d.ext  = p_hi_next ? EXT_HI : EXT_LO;
            st_d.core = mc_next ? 3'd4 : 3'd3;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.core <= 3'd3;
            st_q.ext  <= EXT_LO;
        end else begin
            st_q <= st_d;
        end
    end

    p_core_range_r1: assert property (@(posedge clk) disable iff (rst)
        st_q.core <= 3'd4);
    p_tick_gap_r6: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
endmodule

// File: rtl/psw_cfg_stage.sv
module psw_cfg_stage
    import psw_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic [A_W-1:0] a_in,
    input  logic [B_W-1:0] b_in,
    input  logic           p_hi_in,
    input  logic           apply,
    output div_cfg_t       act_cfg,
    output div_cfg_t       nxt_cfg,
    output logic           err
);
    typedef struct packed {
        div_cfg_t stage;
        logic     pend;
        div_cfg_t act;
        logic     err;
    } cs_t;

    cs_t st_d, st_q;
    div_cfg_t eff;
    logic     bad;

    always_comb begin
        bad    = {{(B_W > A_W ? 0 : A_W - B_W){1'b0}}, st_q.stage.b} <
                 {{(B_W > A_W ? B_W - A_W : 0){1'b0}}, st_q.stage.a};
        eff    = st_q.stage;
        if (st_q.stage.b == '0) eff.b = B_W'(1);
        if (bad) eff.a = '0;
        nxt_cfg = st_q.pend ? eff : st_q.act;
    end

    always_comb begin
        st_d = st_q;
        if (apply && st_q.pend) begin
            st_d.act  = eff;
            st_d.pend = 1'b0;
            if (bad) st_d.err = 1'b1;
        end
        if (load) begin
            st_d.stage.a    = a_in;
            st_d.stage.b    = b_in;
            st_d.stage.p_hi = p_hi_in;
            st_d.pend       = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.stage <= '{a: '0, b: B_W'(1), p_hi: 1'b0};
            st_q.pend  <= 1'b0;
            st_q.act   <= '{a: '0, b: B_W'(1), p_hi: 1'b0};
            st_q.err   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign act_cfg = st_q.act;
    assign err     = st_q.err;

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        st_q.err |=> st_q.err);
    p_act_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !apply |=> $stable(st_q.act));
endmodule

// File: rtl/psw_swallow_ctrl.sv
module psw_swallow_ctrl
    import psw_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  div_cfg_t act_cfg,
    input  div_cfg_t nxt_cfg,
    output logic     boundary,
    output logic     mc_next,
    output logic     p_hi_next,
    output logic     pulse
);
    typedef struct packed {
        logic [A_W-1:0] a_cnt;
        logic [B_W-1:0] b_cnt;
        logic           mc;
        logic           pulse;
    } ctl_t;

    ctl_t st_d, st_q;

    assign boundary = tick && (st_q.b_cnt == B_W'(1));

    always_comb begin
        st_d       = st_q;
        st_d.pulse = boundary;
        if (tick) begin
            if (boundary) begin
                st_d.a_cnt = nxt_cfg.a;
                st_d.b_cnt = nxt_cfg.b;
            end else begin
                st_d.b_cnt = st_q.b_cnt - 1'b1;
                if (st_q.a_cnt != '0) st_d.a_cnt = st_q.a_cnt - 1'b1;
            end
        end
        st_d.mc   = (st_d.a_cnt != '0);
        mc_next   = st_d.mc;
        p_hi_next = boundary ? nxt_cfg.p_hi : act_cfg.p_hi;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.a_cnt <= '0;
            st_q.b_cnt <= B_W'(1);
            st_q.mc    <= 1'b0;
            st_q.pulse <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse = st_q.pulse;

    p_pulse_one_r6: assert property (@(posedge clk) disable iff (rst)
        st_q.pulse |=> !st_q.pulse);
    p_mc_stable_r1: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(st_q.mc));
    p_b_nonzero_r5: assert property (@(posedge clk) disable iff (rst)
        st_q.b_cnt != '0);
    p_a_le_b_r8: assert property (@(posedge clk) disable iff (rst)
        {{(B_W > A_W ? B_W - A_W : 0){1'b0}}, st_q.a_cnt} <=
        {{(B_W > A_W ? 0 : A_W - B_W){1'b0}}, st_q.b_cnt});
endmodule

// File: rtl/pulse_swallow_div.sv
module pulse_swallow_div
    import psw_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           cfg_load,
    input  logic [A_W-1:0] swallow_val,
    input  logic [B_W-1:0] main_val,
    input  logic           mod_hi_sel,
    output logic           fb_pulse,
    output logic           ratio_err
);
    logic     tick, boundary, mc_next, p_hi_next;
    div_cfg_t act_cfg, nxt_cfg;

    psw_prescaler u_pre (
        .clk       (clk),
        .rst       (rst),
        .mc_next   (mc_next),
        .p_hi_next (p_hi_next),
        .tick      (tick)
    );

    psw_cfg_stage u_cfg (
        .clk     (clk),
        .rst     (rst),
        .load    (cfg_load),
        .a_in    (swallow_val),
        .b_in    (main_val),
        .p_hi_in (mod_hi_sel),
        .apply   (boundary),
        .act_cfg (act_cfg),
        .nxt_cfg (nxt_cfg),
        .err     (ratio_err)
    );

    psw_swallow_ctrl u_ctl (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .act_cfg   (act_cfg),
        .nxt_cfg   (nxt_cfg),
        .boundary  (boundary),
        .mc_next   (mc_next),
        .p_hi_next (p_hi_next),
        .pulse     (fb_pulse)
    );
endmodule

// File: tb/sim_pulse_swallow_div.sv
module sim_pulse_swallow_div;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_load = 1'b0;
    logic [5:0]  swallow_val = '0;
    logic [10:0] main_val = '0;
    logic        mod_hi_sel = 1'b0;
    logic        fb_pulse, ratio_err;
    int          n_chk = 0, n_err = 0;
    longint      cyc = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pulse_swallow_div u0 (
        .clk(clk), .rst(rst), .cfg_load(cfg_load), .swallow_val(swallow_val),
        .main_val(main_val), .mod_hi_sel(mod_hi_sel),
        .fb_pulse(fb_pulse), .ratio_err(ratio_err)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_pulse();
        do @(negedge clk); while (!fb_pulse);
    endtask

    task automatic measure(output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!fb_pulse);
    endtask

    task automatic do_load(input int b, input int a, input bit hi);
        main_val = 11'(b); swallow_val = 6'(a); mod_hi_sel = hi;
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    task automatic apply_and_measure(input string req, input int b, input int a, input bit hi, input int exp);
        int n;
        wait_pulse();
        do_load(b, a, hi);
        wait_pulse();
        measure(n);
        check(req, n, exp);
    endtask

    task automatic t_reset();
        int n;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R10 out low", fb_pulse, 0);
        check("R10 err low", ratio_err, 0);
        rst = 1'b0;
        wait_pulse();
        measure(n);
        check("R10 default interval", n, 32);
    endtask

    task automatic t_lo();
        apply_and_measure("R1 P32 B10 A5", 10, 5, 1'b0, 325);
        apply_and_measure("R1 P32 B3 A2", 3, 2, 1'b0, 98);
    endtask

    task automatic t_hi();
        int n;
        apply_and_measure("R2 P64 B10 A5", 10, 5, 1'b1, 645);
        measure(n);
        check("R2 repeat interval", n, 645);
    endtask

    task automatic t_a_zero();
        apply_and_measure("R3 P64 B7 A0", 7, 0, 1'b1, 448);
    endtask

    task automatic t_a_eq_b();
        apply_and_measure("R4 P32 B20 A20", 20, 20, 1'b0, 660);
        check("R4 no error", ratio_err, 0);
    endtask

    task automatic t_small_b();
        apply_and_measure("R5 P64 B1 A0", 1, 0, 1'b1, 64);
        apply_and_measure("R5 P32 B1 A1", 1, 1, 1'b0, 33);
    endtask

    task automatic t_width();
        int hi_cnt;
        wait_pulse();
        hi_cnt = 0;
        while (fb_pulse) begin hi_cnt++; @(negedge clk); end
        check("R6 pulse width", hi_cnt, 1);
    endtask

    task automatic t_mid_load();
        int n;
        wait_pulse();
        do_load(4, 1, 1'b0);
        wait_pulse();
        measure(n);
        check("R7 base interval", n, 129);
        repeat (5) @(negedge clk);
        do_load(6, 3, 1'b1);
        n = 6;
        do begin @(negedge clk); n++; end while (!fb_pulse);
        check("R7 cycle in progress unchanged", n, 129);
        measure(n);
        check("R7 next cycle new setting", n, 387);
    endtask

    task automatic t_multi_load();
        int n;
        wait_pulse();
        do_load(4, 0, 1'b0);
        repeat (3) @(negedge clk);
        do_load(6, 0, 1'b0);
        wait_pulse();
        measure(n);
        check("R11 last load wins", n, 192);
    endtask

    task automatic t_bad();
        int n;
        check("R8 err low before", ratio_err, 0);
        apply_and_measure("R8 fallback B2 A5", 2, 5, 1'b0, 64);
        check("R8 err set", ratio_err, 1);
        apply_and_measure("R9 valid after error", 3, 1, 1'b0, 97);
        check("R9 err sticky", ratio_err, 1);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R9 reset clears err", ratio_err, 0);
        wait_pulse();
        measure(n);
        check("R10 default after reset", n, 32);
    endtask

    task automatic t_big_b();
        apply_and_measure("R5 P32 B2047 A63", 2047, 63, 1'b0, 65567);
    endtask

    initial begin : watchdog
        wait (cyc >= 190000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=%0d expected=<190000 cycles", cyc);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_lo();
        t_hi();
        t_a_zero();
        t_a_eq_b();
        t_small_b();
        t_width();
        t_mid_load();
        t_multi_load();
        t_bad();
        t_big_b();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule